// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block takes one 32-bit instruction word of a load/store style machine and turns it, in pure combinational logic, into everything the later pipeline stages need. It first sorts the word into register, immediate or jump format using the six opcode bits alone. It then slices out every field and widens the 16-bit constant to 32 bits with its sign kept. Last, it produces the destination register index and the control strobes for a small supported set: add, sub, addi, lw, sw, beq and j.

The register file, ALU and memory sit outside. They take the register indices, the widened constant, the 26-bit jump field and the strobes from this block. A word whose opcode, or whose function code under opcode 0, is outside the supported set raises an illegal flag. With that flag high, no register and no memory can be written, so a downstream trap can take over cleanly. The one slot of the immediate format that names the second register has two roles. It is the destination for loads and addi, and a source for stores. Only the opcode settles which role applies.

Top module: `insn_fmt_decoder`

## Requirements
- R1: The format code depends only on bits 31:26 (opcode). Opcode 0 gives code 0 (register), opcode 2 or 3 gives code 2 (jump), and any other opcode gives code 1 (immediate). Code 3 never appears.
- R2: The fields are always sliced from the word whatever the format: opcode = bits 31:26, rs = 25:21, rt = 20:16, rd = 15:11, shamt = 10:6, funct = 5:0, jump field = 25:0.
- R3: The 32-bit immediate equals bits 15:0 of the word with bit 15 copied into bits 31:16 (for example 0xFFFF becomes 0xFFFFFFFF and 0x7FFF stays 0x00007FFF).
- R4: Opcode 0 with funct 32 (add) or funct 34 (sub) sets register-write, and the destination equals rd. The memory, branch and jump strobes stay low.
- R5: Opcode 8 (addi) and opcode 35 (lw) set register-write, and the destination equals rt. Memory-read is high only for lw.
- R6: Opcode 43 (sw) sets memory-write and leaves register-write low with destination 0, so rt acts as a source.
- R7: Opcode 4 (beq) sets only the branch strobe and opcode 2 (j) sets only the jump strobe. Neither writes a register, and the destination is 0 for both.
- R8: Any opcode outside {0, 2, 4, 8, 35, 43}, and opcode 0 with a funct other than 32 or 34, sets the illegal flag. In that case every strobe is low and the destination is 0, while the format code still follows R1.
- R9: At most one of memory-read, memory-write, branch and jump is high for any word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| fmt_o | output | 2 | Format code: 0 register, 1 immediate, 2 jump |
| opcode_o | output | 6 | Opcode field |
| rs_o | output | 5 | First source register index |
| rt_o | output | 5 | Second register index (source or destination) |
| rd_o | output | 5 | Register-format destination slot |
| shamt_o | output | 5 | Shift amount field |
| funct_o | output | 6 | Function code field |
| imm_o | output | 32 | Sign-extended 16-bit constant |
| jfield_o | output | 26 | Raw jump target field |
| dest_o | output | 5 | Register to be written, 0 when none |
| reg_we_o | output | 1 | Register-write strobe |
| mem_rd_o | output | 1 | Memory-read strobe |
| mem_wr_o | output | 1 | Memory-write strobe |
| branch_o | output | 1 | Conditional branch strobe |
| jump_o | output | 1 | Unconditional jump strobe |
| illegal_o | output | 1 | Unsupported opcode or function code |

## Verification
Format classification and the illegal check act on the same word in the same evaluation. The sharp cases are words where they disagree with intuition. Opcode 3 must read as jump format yet be illegal with no jump strobe. Opcode 0 with funct 33 must read as register format yet be illegal with register-write low. The stimulus draws opcodes and function codes from a biased mix of supported values, these near misses and fully random values. Each word is judged against expected values that the bench derives from the requirement text alone, and the illegal cases check the format code next to the suppressed strobes.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  localparam int WORD_W  = 32;
  localparam int OP_W    = 6;
  localparam int REG_W   = 5;
  localparam int SHAMT_W = 5;
  localparam int FUNCT_W = 6;
  localparam int IMM_W   = 16;
  localparam int JF_W    = WORD_W - OP_W;

  localparam int OP_LSB  = WORD_W - OP_W;
  localparam int RS_LSB  = OP_LSB - REG_W;
  localparam int RT_LSB  = RS_LSB - REG_W;
  localparam int RD_LSB  = RT_LSB - REG_W;
  localparam int SH_LSB  = RD_LSB - SHAMT_W;

  typedef enum logic [1:0] {
    FMT_REG = 2'd0,
    FMT_IMM = 2'd1,
    FMT_JMP = 2'd2
  } fmt_e;

  localparam logic [OP_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OP_W-1:0] OPC_JUMP    = 6'd2;
  localparam logic [OP_W-1:0] OPC_JLINK   = 6'd3;
  localparam logic [OP_W-1:0] OPC_BEQ     = 6'd4;
  localparam logic [OP_W-1:0] OPC_ADDI    = 6'd8;
  localparam logic [OP_W-1:0] OPC_LOAD    = 6'd35;
  localparam logic [OP_W-1:0] OPC_STORE   = 6'd43;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'd32;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'd34;

  function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic fmt_e fmt_of(input logic [OP_W-1:0] op);
    if (op == OPC_SPECIAL)                    return FMT_REG;
    else if (op == OPC_JUMP || op == OPC_JLINK) return FMT_JMP;
    else                                      return FMT_IMM;
  endfunction

endpackage

// File: rtl/insn_field_split.sv
module insn_field_split
  import insn_dec_pkg::*;
(
  input  logic [WORD_W-1:0]  word_i,
  output logic [OP_W-1:0]    op_o,
  output logic [REG_W-1:0]   rs_o,
  output logic [REG_W-1:0]   rt_o,
  output logic [REG_W-1:0]   rd_o,
  output logic [SHAMT_W-1:0] sh_o,
  output logic [FUNCT_W-1:0] fn_o,
  output logic [WORD_W-1:0]  imm_o,
  output logic [JF_W-1:0]    jf_o
);

  assign op_o  = word_i[OP_LSB +: OP_W];
  assign rs_o  = word_i[RS_LSB +: REG_W];
  assign rt_o  = word_i[RT_LSB +: REG_W];
  assign rd_o  = word_i[RD_LSB +: REG_W];
  assign sh_o  = word_i[SH_LSB +: SHAMT_W];
  assign fn_o  = word_i[0 +: FUNCT_W];
  assign jf_o  = word_i[0 +: JF_W];
  assign imm_o = sext_imm(word_i[0 +: IMM_W]);

endmodule

// File: rtl/insn_fmt_classify.sv
module insn_fmt_classify
  import insn_dec_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output fmt_e            fmt_o
);

  assign fmt_o = fmt_of(op_i);

endmodule

// File: rtl/insn_ctrl_decode.sv
module insn_ctrl_decode
  import insn_dec_pkg::*;
(
  input  logic [OP_W-1:0]    op_i,
  input  logic [FUNCT_W-1:0] fn_i,
  input  logic [REG_W-1:0]   rt_i,
  input  logic [REG_W-1:0]   rd_i,
  output logic [REG_W-1:0]   dest_o,
  output logic               reg_we_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic               branch_o,
  output logic               jump_o,
  output logic               illegal_o
);

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_RD   = 2'd1,
    DST_RT   = 2'd2
  } dst_sel_e;

  dst_sel_e dst_sel;
  logic     known;

  always_comb begin
    dst_sel  = DST_NONE;
    known    = 1'b0;
    mem_rd_o = 1'b0;
    mem_wr_o = 1'b0;
    branch_o = 1'b0;
    jump_o   = 1'b0;
    case (op_i)
      OPC_SPECIAL: begin
        if (fn_i == FN_ADD || fn_i == FN_SUB) begin
          known   = 1'b1;
          dst_sel = DST_RD;
        end
      end
      OPC_ADDI: begin
        known   = 1'b1;
        dst_sel = DST_RT;
      end
      OPC_LOAD: begin
        known    = 1'b1;
        dst_sel  = DST_RT;
        mem_rd_o = 1'b1;
      end
      OPC_STORE: begin
        known    = 1'b1;
        mem_wr_o = 1'b1;
      end
      OPC_BEQ: begin
        known    = 1'b1;
        branch_o = 1'b1;
      end
      OPC_JUMP: begin
        known  = 1'b1;
        jump_o = 1'b1;
      end
      default: begin
        known = 1'b0;
      end
    endcase
  end

  always_comb begin
    case (dst_sel)
      DST_RD:  dest_o = rd_i;
      DST_RT:  dest_o = rt_i;
      default: dest_o = '0;
    endcase
  end

  assign reg_we_o  = known && (dst_sel != DST_NONE);
  assign illegal_o = !known;

endmodule

// File: rtl/insn_fmt_decoder.sv
module insn_fmt_decoder
  import insn_dec_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [1:0]  fmt_o,
  output logic [5:0]  opcode_o,
  output logic [4:0]  rs_o,
  output logic [4:0]  rt_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  shamt_o,
  output logic [5:0]  funct_o,
  output logic [31:0] imm_o,
  output logic [25:0] jfield_o,
  output logic [4:0]  dest_o,
  output logic        reg_we_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic        branch_o,
  output logic        jump_o,
  output logic        illegal_o
);

  logic [OP_W-1:0]    op_w;
  logic [FUNCT_W-1:0] fn_w;
  logic [REG_W-1:0]   rt_w;
  logic [REG_W-1:0]   rd_w;
  fmt_e               fmt_w;

  insn_field_split u_split (
    .word_i (instr_i),
    .op_o   (op_w),
    .rs_o   (rs_o),
    .rt_o   (rt_w),
    .rd_o   (rd_w),
    .sh_o   (shamt_o),
    .fn_o   (fn_w),
    .imm_o  (imm_o),
    .jf_o   (jfield_o)
  );

  insn_fmt_classify u_fmt (
    .op_i  (op_w),
    .fmt_o (fmt_w)
  );

  insn_ctrl_decode u_ctrl (
    .op_i      (op_w),
    .fn_i      (fn_w),
    .rt_i      (rt_w),
    .rd_i      (rd_w),
    .dest_o    (dest_o),
    .reg_we_o  (reg_we_o),
    .mem_rd_o  (mem_rd_o),
    .mem_wr_o  (mem_wr_o),
    .branch_o  (branch_o),
    .jump_o    (jump_o),
    .illegal_o (illegal_o)
  );

  assign fmt_o    = fmt_w;
  assign opcode_o = op_w;
  assign funct_o  = fn_w;
  assign rt_o     = rt_w;
  assign rd_o     = rd_w;

endmodule

// File: rtl/insn_dec_chk.sv
module insn_dec_chk (
  input logic [31:0] instr_i,
  input logic [1:0]  fmt_o,
  input logic [4:0]  rt_o,
  input logic [4:0]  rd_o,
  input logic [31:0] imm_o,
  input logic [4:0]  dest_o,
  input logic        reg_we_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        branch_o,
  input logic        jump_o,
  input logic        illegal_o
);

  always_comb begin
    if (!$isunknown(instr_i)) begin
      a_r1_fmt_code: assert (fmt_o != 2'd3);
      a_r1_reg_fmt: assert ((instr_i[31:26] == 6'd0) == (fmt_o == 2'd0));
      a_r3_sign_fill: assert (imm_o[31:16] == {16{instr_i[15]}} && imm_o[15:0] == instr_i[15:0]);
      a_r4_dest_rd: assert (!(reg_we_o && fmt_o == 2'd0) || dest_o == rd_o);
      a_r5_dest_rt: assert (!(reg_we_o && fmt_o == 2'd1) || dest_o == rt_o);
      a_r6_store_nowrite: assert (!mem_wr_o || (!reg_we_o && dest_o == 5'd0));
      a_r7_ctl_nowrite: assert (!(branch_o || jump_o) || !reg_we_o);
      a_r8_illegal_quiet: assert (!illegal_o ||
        (!reg_we_o && !mem_wr_o && !mem_rd_o && !branch_o && !jump_o && dest_o == 5'd0));
      a_r9_one_strobe: assert ($onehot0({mem_rd_o, mem_wr_o, branch_o, jump_o}));
    end
  end

endmodule

bind insn_fmt_decoder insn_dec_chk u_chk (
  .instr_i   (instr_i),
  .fmt_o     (fmt_o),
  .rt_o      (rt_o),
  .rd_o      (rd_o),
  .imm_o     (imm_o),
  .dest_o    (dest_o),
  .reg_we_o  (reg_we_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .branch_o  (branch_o),
  .jump_o    (jump_o),
  .illegal_o (illegal_o)
);

// File: tb/insn_fmt_decoder_tb.sv
module insn_fmt_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [1:0]  fmt;
  logic [5:0]  opcode;
  logic [4:0]  rs, rt, rd, shamt, dest;
  logic [5:0]  funct;
  logic [31:0] imm;
  logic [25:0] jfield;
  logic        reg_we, mem_rd, mem_wr, branch, jump, illegal;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_fmt_decoder u_dut (
    .instr_i   (instr),
    .fmt_o     (fmt),
    .opcode_o  (opcode),
    .rs_o      (rs),
    .rt_o      (rt),
    .rd_o      (rd),
    .shamt_o   (shamt),
    .funct_o   (funct),
    .imm_o     (imm),
    .jfield_o  (jfield),
    .dest_o    (dest),
    .reg_we_o  (reg_we),
    .mem_rd_o  (mem_rd),
    .mem_wr_o  (mem_wr),
    .branch_o  (branch),
    .jump_o    (jump),
    .illegal_o (illegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp, input logic [31:0] w);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s word=%h: actual %h expected %h", req, what, w, act, exp);
    end
  endtask

  function automatic logic [31:0] widen(input logic [31:0] w);
    int v;
    v = int'(w % 32'h10000);
    if (v >= 32768) v = v - 65536;
    return 32'(v);
  endfunction

  task automatic check_word(input logic [31:0] w);
    int unsigned op, fn;
    logic [1:0]  e_fmt;
    logic [4:0]  e_dest;
    logic        e_we, e_mr, e_mw, e_br, e_jp, e_il;
    op = w >> 26;
    fn = w & 32'h3F;
    e_fmt = (op == 0) ? 2'd0 : ((op == 2 || op == 3) ? 2'd2 : 2'd1);
    e_we = 0; e_mr = 0; e_mw = 0; e_br = 0; e_jp = 0; e_il = 0; e_dest = 5'd0;
    if (op == 0 && (fn == 32 || fn == 34)) begin
      e_we = 1; e_dest = 5'((w >> 11) & 32'h1F);
    end else if (op == 8 || op == 35) begin
      e_we = 1; e_dest = 5'((w >> 16) & 32'h1F); e_mr = (op == 35);
    end else if (op == 43) e_mw = 1;
    else if (op == 4) e_br = 1;
    else if (op == 2) e_jp = 1;
    else e_il = 1;

    @(posedge clk);
    instr = w;
    @(negedge clk);
    chk("R1", "format", 32'(fmt), 32'(e_fmt), w);
    chk("R2", "opcode", 32'(opcode), op, w);
    chk("R2", "rs", 32'(rs), (w >> 21) & 32'h1F, w);
    chk("R2", "rt", 32'(rt), (w >> 16) & 32'h1F, w);
    chk("R2", "rd", 32'(rd), (w >> 11) & 32'h1F, w);
    chk("R2", "shamt", 32'(shamt), (w >> 6) & 32'h1F, w);
    chk("R2", "funct", 32'(funct), fn, w);
    chk("R2", "jfield", 32'(jfield), w & 32'h03FFFFFF, w);
    chk("R3", "imm", imm, widen(w), w);
    chk(e_il ? "R8" : (op == 0 ? "R4" : (op == 8 || op == 35 ? "R5" : (op == 43 ? "R6" : "R7"))),
        "dest/we/mr/mw/br/jp/il",
        {20'd0, e_dest == dest, reg_we, mem_rd, mem_wr, branch, jump, illegal, 5'd0},
        {20'd0, 1'b1, e_we, e_mr, e_mw, e_br, e_jp, e_il, 5'd0}, w);
    chk("R9", "strobe count", 32'($countones({mem_rd, mem_wr, branch, jump}) > 1), 32'd0, w);
  endtask

  function automatic logic [31:0] rand_word();
    int unsigned r, sel;
    logic [5:0] op;
    logic [5:0] fn;
    r = $urandom;
    sel = $urandom_range(0, 11);
    case (sel)
      0, 1:    op = 6'd0;
      2:       op = 6'd2;
      3:       op = 6'd3;
      4:       op = 6'd4;
      5:       op = 6'd8;
      6:       op = 6'd35;
      7:       op = 6'd43;
      8:       op = 6'd63;
      default: op = 6'($urandom_range(0, 63));
    endcase
    sel = $urandom_range(0, 3);
    case (sel)
      0:       fn = 6'd32;
      1:       fn = 6'd34;
      2:       fn = 6'd33;
      default: fn = 6'($urandom_range(0, 63));
    endcase
    return {op, r[25:6], fn};
  endfunction

  initial begin
    #(CLK_PERIOD * 120000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    @(negedge clk);
    // reset state: all-zero word is opcode 0, funct 0 -> register format, illegal (R8)
    chk("R8", "reset illegal", 32'(illegal), 32'd1, instr);
    chk("R1", "reset format", 32'(fmt), 32'd0, instr);
    rst_n = 1'b1;

    // directed words
    check_word(32'h012A4020);  // add: R4, dest rd=8
    chk("R4", "add dest", 32'(dest), 32'd8, 32'h012A4020);
    check_word(32'h02328022);  // sub: R4, dest rd=16
    chk("R4", "sub dest", 32'(dest), 32'd16, 32'h02328022);
    check_word(32'h8D0A0010);  // lw: R5
    chk("R5", "lw imm", imm, 32'd16, 32'h8D0A0010);
    chk("R5", "lw dest", 32'(dest), 32'd10, 32'h8D0A0010);
    check_word(32'h2210FFFF);  // addi -1: R3
    chk("R3", "imm -1", imm, 32'hFFFFFFFF, 32'h2210FFFF);
    check_word(32'h2128FFFD);
    chk("R3", "imm -3", imm, 32'hFFFFFFFD, 32'h2128FFFD);
    chk("R5", "addi dest", 32'(dest), 32'd8, 32'h2128FFFD);
    check_word(32'hAE6AFFFC);  // sw: R6
    chk("R6", "sw write", {31'd0, mem_wr}, 32'd1, 32'hAE6AFFFC);
    chk("R6", "sw no reg", {31'd0, reg_we}, 32'd0, 32'hAE6AFFFC);
    check_word(32'h08100009);  // j: R7
    chk("R7", "j field", 32'(jfield), 32'h0100009, 32'h08100009);
    chk("R7", "j strobe", {31'd0, jump}, 32'd1, 32'h08100009);
    check_word(32'h1109FFFB);  // beq: R7
    chk("R7", "beq strobe", {31'd0, branch}, 32'd1, 32'h1109FFFB);
    check_word(32'h21097FFF);  // R3 positive edge
    chk("R3", "imm 0x7FFF", imm, 32'h00007FFF, 32'h21097FFF);
    check_word(32'h21098000);  // R3 negative edge
    chk("R3", "imm 0x8000", imm, 32'hFFFF8000, 32'h21098000);
    check_word(32'h0C100009);  // opcode 3: jump format but illegal (R8)
    chk("R8", "op3 format", 32'(fmt), 32'd2, 32'h0C100009);
    chk("R8", "op3 illegal", {31'd0, illegal}, 32'd1, 32'h0C100009);
    check_word(32'h012A4021);  // funct 33 illegal (R8)
    chk("R8", "funct33 format", 32'(fmt), 32'd0, 32'h012A4021);
    chk("R8", "funct33 we", {31'd0, reg_we}, 32'd0, 32'h012A4021);
    check_word(32'hFFFFFFFF);  // opcode 63 illegal (R8)
    check_word(32'h00000000);

    for (int i = 0; i < N_RANDOM; i++) check_word(rand_word());

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule